// File: doc/BRIEF.md
# Stage-Select Timer and Divider

This block is a fully synchronous timer built around a binary counter that advances once per accepted count pulse. A two-bit stage code picks one of four counter stages as the tap. In recycle mode the tapped stage drives the output, so the output is a square wave whose period is 2^N accepted pulses, where N is the selected stage. In single-transition mode the output rises once the tapped stage first becomes 1, which happens after 2^(N-1) pulses. It then stays high until a master reset arrives or until recycle mode is selected. An inversion input flips the output sense.

The count input is a one-cycle enable that is sampled on the system clock. No derived clock exists. The counter only sees a pulse while the controller is in its counting state and no reset is active, which stands in for stopping the oscillator during reset. A synchronous power-on input starts the controller. What it does next depends on the arm-hold input. With arm-hold low the power-on input acts like a master reset and counting starts when it is released. With arm-hold high the controller waits in an armed state until a complete master-reset pulse has been seen, high and then low again.

Controller states: `ST_CLEAR` (reset held, counter cleared), `ST_ARM_WAIT` (armed, waiting for a master-reset pulse), `ST_ARM_HELD` (armed, master reset currently high), `ST_COUNT` (counting), `ST_LATCHED` (single-transition output latched, counter frozen). Transitions:
- power-on: to `ST_ARM_WAIT` if arm-hold is high, otherwise to `ST_CLEAR`.
- `ST_ARM_WAIT`: to `ST_ARM_HELD` on master reset high.
- `ST_ARM_HELD`: to `ST_COUNT` on master reset low.
- `ST_CLEAR`: to `ST_COUNT` on master reset low.
- `ST_COUNT`: to `ST_CLEAR` on master reset. Otherwise to `ST_LATCHED` when single-transition mode is set and the tap is 1.
- `ST_LATCHED`: to `ST_CLEAR` on master reset. Otherwise to `ST_COUNT` when recycle mode is set.

Top module: `stage_timer`

## Requirements
- R1: The counter advances by exactly one on each clock edge where a count pulse is accepted, and holds its value otherwise.
- R2: The stage code {sel_hi, sel_lo} selects the tapped stage N as follows: 2'b00 gives TAP_00 (default 13), 2'b01 gives TAP_01 (default 10), 2'b10 gives TAP_10 (default 8) and 2'b11 gives TAP_11 (default 16). Stage N is counter bit N-1.
- R3: With recycle=1, after k accepted pulses since reset the non-inverted output equals bit N-1 of k. The output is therefore a square wave with a period of 2^N pulses.
- R4: With recycle=0, the non-inverted output is 0 for k < 2^(N-1) and 1 for k >= 2^(N-1). Once latched it stays 1 through any later pulses until a master reset or recycle=1.
- R5: tmr_out equals the non-inverted output XOR inv_out. In every reset or armed state tmr_out therefore equals inv_out.
- R6: mrst high in any state clears the counter and the latch. Count pulses seen while mrst is high, including in the same cycle, are not counted.
- R7: With hold_arm=0, a por pulse acts like a master reset. Count pulses are accepted from the second rising edge after por falls.
- R8: With hold_arm=1 at por, count pulses are ignored until mrst has been high and then low. Pulses are accepted from the second rising edge after mrst falls.
- R9: A change of the stage code takes effect on tmr_out only after the next rising clock edge.
- R10: In the latched state, setting recycle=1 returns the controller to counting from the frozen count 2^(N-1). The output then follows the tapped bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| por | input | 1 | Synchronous power-on reset, active high |
| cnt_en | input | 1 | One-cycle count pulse |
| mrst | input | 1 | Master reset, active high |
| hold_arm | input | 1 | 1: after power-on, wait for a master-reset pulse before counting |
| recycle | input | 1 | 1: recycle (divider) mode, 0: single-transition mode |
| inv_out | input | 1 | 1: invert the output |
| sel_hi | input | 1 | Stage code, upper bit |
| sel_lo | input | 1 | Stage code, lower bit |
| tmr_out | output | 1 | Timer output |

## Verification
A pulse that is accepted on a rising edge shows up on tmr_out right after that same edge, because the tap is read straight from the counter register. The bench drives each pulse at a falling edge and compares at the next falling edge, so every comparison follows exactly one rising edge. Reset releases cost one extra edge (controller into the counting state) before pulses count. A stage-code change is sampled twice: once just after the change, where the old tap must still be visible, and once after the following rising edge, where the new tap must be visible. Changes to inv_out act combinationally and are checked in the same cycle as the reset level.

// File: rtl/stage_timer_pkg.sv
package stage_timer_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR    = 3'd0,
        ST_ARM_WAIT = 3'd1,
        ST_ARM_HELD = 3'd2,
        ST_COUNT    = 3'd3,
        ST_LATCHED  = 3'd4
    } tmr_state_e;

    localparam int NUM_TAPS = 4;

endpackage

// File: rtl/stage_timer_counter.sv
module stage_timer_counter #(
    parameter int CNT_W  = 16,
    parameter int TAP_00 = 13,
    parameter int TAP_01 = 10,
    parameter int TAP_10 = 8,
    parameter int TAP_11 = 16
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       go,
    output logic [stage_timer_pkg::NUM_TAPS-1:0] tap_vec
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] carry;

    // Ripple-style toggle chain: each stage flips when all lower stages are 1.
    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        if (i == 0) begin : g_lsb
            assign carry[i] = go;
        end else begin : g_up
            assign carry[i] = carry[i-1] & cnt_q[i-1];
        end

        always_ff @(posedge clk) begin
            if (clr) begin
                cnt_q[i] <= 1'b0;
            end else if (carry[i]) begin
                cnt_q[i] <= ~cnt_q[i];
            end
        end
    end

    // Stage N is counter bit N-1.
    for (genvar g = 0; g < stage_timer_pkg::NUM_TAPS; g++) begin : g_tap
        localparam int IDX = (g == 0) ? TAP_00 - 1 :
                             (g == 1) ? TAP_01 - 1 :
                             (g == 2) ? TAP_10 - 1 : TAP_11 - 1;
        assign tap_vec[g] = cnt_q[IDX];
    end

endmodule

// File: rtl/stage_timer_tapsel.sv
module stage_timer_tapsel (
    input  logic       clk,
    input  logic       sel_hi,
    input  logic       sel_lo,
    input  logic [stage_timer_pkg::NUM_TAPS-1:0] tap_vec,
    output logic       tap_bit
);

    logic [1:0] sel_q;

    // Registered stage code: a new selection applies after the next edge.
    always_ff @(posedge clk) begin
        sel_q <= {sel_hi, sel_lo};
    end

    assign tap_bit = tap_vec[sel_q];

endmodule

// File: rtl/stage_timer_ctrl.sv
module stage_timer_ctrl
    import stage_timer_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       hold_arm,
    input  logic       mrst,
    input  logic       recycle,
    input  logic       cnt_en,
    input  logic       tap_bit,
    output tmr_state_e state_q,
    output logic       cnt_clr,
    output logic       cnt_go,
    output logic       out_raw
);

    tmr_state_e state_d;
    logic       latch_now;

    assign latch_now = !recycle && tap_bit;

    // State register
    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= hold_arm ? ST_ARM_WAIT : ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM_WAIT: if (mrst)  state_d = ST_ARM_HELD;
            ST_ARM_HELD: if (!mrst) state_d = ST_COUNT;
            ST_CLEAR:    if (!mrst) state_d = ST_COUNT;
            ST_COUNT: begin
                if (mrst)           state_d = ST_CLEAR;
                else if (latch_now) state_d = ST_LATCHED;
            end
            ST_LATCHED: begin
                if (mrst)           state_d = ST_CLEAR;
                else if (recycle)   state_d = ST_COUNT;
            end
            default:                state_d = ST_CLEAR;
        endcase
    end

    // Outputs: counter gate, clear and the un-inverted timer level
    always_comb begin
        cnt_clr = por || mrst;
        cnt_go  = 1'b0;
        out_raw = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                cnt_go  = cnt_en && !mrst && !latch_now;
                out_raw = tap_bit;
            end
            ST_LATCHED: out_raw = 1'b1;
            ST_CLEAR, ST_ARM_WAIT, ST_ARM_HELD: out_raw = 1'b0;
            default: out_raw = 1'b0;
        endcase
    end

endmodule

// File: rtl/stage_timer.sv
module stage_timer #(
    parameter int CNT_W  = 16,
    parameter int TAP_00 = 13,
    parameter int TAP_01 = 10,
    parameter int TAP_10 = 8,
    parameter int TAP_11 = 16
) (
    input  logic clk,
    input  logic por,
    input  logic cnt_en,
    input  logic mrst,
    input  logic hold_arm,
    input  logic recycle,
    input  logic inv_out,
    input  logic sel_hi,
    input  logic sel_lo,
    output logic tmr_out
);

    import stage_timer_pkg::*;

    tmr_state_e            state_q;
    logic                  cnt_clr;
    logic                  cnt_go;
    logic                  out_raw;
    logic                  tap_bit;
    logic [NUM_TAPS-1:0]   tap_vec;

    stage_timer_ctrl u_ctrl (
        .clk      (clk),
        .por      (por),
        .hold_arm (hold_arm),
        .mrst     (mrst),
        .recycle  (recycle),
        .cnt_en   (cnt_en),
        .tap_bit  (tap_bit),
        .state_q  (state_q),
        .cnt_clr  (cnt_clr),
        .cnt_go   (cnt_go),
        .out_raw  (out_raw)
    );

    stage_timer_counter #(
        .CNT_W  (CNT_W),
        .TAP_00 (TAP_00),
        .TAP_01 (TAP_01),
        .TAP_10 (TAP_10),
        .TAP_11 (TAP_11)
    ) u_cnt (
        .clk     (clk),
        .clr     (cnt_clr),
        .go      (cnt_go),
        .tap_vec (tap_vec)
    );

    stage_timer_tapsel u_tap (
        .clk     (clk),
        .sel_hi  (sel_hi),
        .sel_lo  (sel_lo),
        .tap_vec (tap_vec),
        .tap_bit (tap_bit)
    );

    assign tmr_out = out_raw ^ inv_out;

endmodule

// File: rtl/stage_timer_chk.sv
module stage_timer_chk
    import stage_timer_pkg::*;
(
    input logic       clk,
    input logic       por,
    input logic       mrst,
    input logic       recycle,
    input logic       inv_out,
    input logic       sel_hi,
    input logic       sel_lo,
    input logic       tmr_out,
    input tmr_state_e state_q,
    input logic       cnt_go,
    input logic       out_raw,
    input logic       tap_bit,
    input logic [NUM_TAPS-1:0] tap_vec
);

    // R1: without an accepted pulse or a clear, every tap holds
    p_hold_r1: assert property (@(posedge clk) disable iff (por)
        (!cnt_go && !mrst) |=> $stable(tap_vec));

    // R3: in recycle counting the level follows the selected stage
    p_follow_r3: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_COUNT && recycle) |-> (out_raw == tap_bit));

    // R4: a latched output stays high while no reset or mode change occurs
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_LATCHED && !mrst && !recycle) |=> out_raw);

    // R5: after a master reset the output shows the inversion level
    p_reset_level_r5: assert property (@(posedge clk) disable iff (por)
        mrst |=> (tmr_out == inv_out));

    // R6: no pulse is accepted while master reset is high
    p_gate_r6: assert property (@(posedge clk) disable iff (por)
        (mrst || state_q != ST_COUNT) |-> !cnt_go);

    // R8: the armed wait is left only through a master-reset pulse
    p_arm_r8: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_ARM_WAIT && !mrst) |=> (state_q == ST_ARM_WAIT));

    // R9: the tap follows the stage code from one edge earlier
    p_sel_delay_r9: assert property (@(posedge clk) disable iff (por)
        tap_bit == tap_vec[$past({sel_hi, sel_lo})]);

    // R10: recycle mode releases the latch
    p_release_r10: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_LATCHED && recycle && !mrst) |=> (state_q == ST_COUNT));

endmodule

bind stage_timer stage_timer_chk u_chk (
    .clk     (clk),
    .por     (por),
    .mrst    (mrst),
    .recycle (recycle),
    .inv_out (inv_out),
    .sel_hi  (sel_hi),
    .sel_lo  (sel_lo),
    .tmr_out (tmr_out),
    .state_q (state_q),
    .cnt_go  (cnt_go),
    .out_raw (out_raw),
    .tap_bit (tap_bit),
    .tap_vec (tap_vec)
);

// File: tb/stage_timer_bench.sv
module stage_timer_bench;

    localparam int CW = 8;
    localparam int T00 = 6;
    localparam int T01 = 4;
    localparam int T10 = 3;
    localparam int T11 = 8;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic cnt_en = 1'b0;
    logic mrst = 1'b0;
    logic hold_arm = 1'b0;
    logic recycle = 1'b0;
    logic inv_out = 1'b0;
    logic sel_hi = 1'b0;
    logic sel_lo = 1'b0;
    logic tmr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    stage_timer #(
        .CNT_W(CW), .TAP_00(T00), .TAP_01(T01), .TAP_10(T10), .TAP_11(T11)
    ) u_stage_timer (
        .clk(clk), .por(por), .cnt_en(cnt_en), .mrst(mrst), .hold_arm(hold_arm),
        .recycle(recycle), .inv_out(inv_out), .sel_hi(sel_hi), .sel_lo(sel_lo),
        .tmr_out(tmr_out)
    );

    always #4 clk = ~clk;

    function automatic int tap_of(int s);
        case (s)
            0: return T00;
            1: return T01;
            2: return T10;
            default: return T11;
        endcase
    endfunction

    task automatic chk(string req, logic exp);
        checks++;
        if (tmr_out !== exp) begin
            errors++;
            $display("FAIL %s: tmr_out=%b expected %b at %0t", req, tmr_out, exp, $time);
        end
    endtask

    // por held over two edges, then released; returns at the negedge of release
    task automatic do_por(logic ha);
        @(negedge clk);
        por = 1'b1; mrst = 1'b0; cnt_en = 1'b0; hold_arm = ha;
        @(negedge clk);
        @(negedge clk);
        por = 1'b0;
    endtask

    // one accepted-candidate pulse over exactly one rising edge
    task automatic pulse();
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic set_sel(int s);
        sel_hi = s[1];
        sel_lo = s[0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Sweep: every stage code, both modes, both polarities (R2, R3, R4, R5, R7)
        for (int s = 0; s < 4; s++) begin
            for (int md = 0; md < 2; md++) begin
                for (int pl = 0; pl < 2; pl++) begin
                    int n;
                    int kmax;
                    n = tap_of(s);
                    set_sel(s);
                    recycle = md[0];
                    inv_out = pl[0];
                    do_por(1'b0);
                    @(negedge clk);
                    chk("R5 R7 reset level", pl[0]);
                    kmax = md ? 2 * (1 << n) + 3 : (1 << n) + 4;
                    for (int k = 1; k <= kmax; k++) begin
                        logic e;
                        pulse();
                        if (md != 0) e = logic'((k >> (n - 1)) & 1);
                        else         e = (k >= (1 << (n - 1)));
                        chk(md ? "R1 R2 R3 recycle" : "R1 R2 R4 single", e ^ pl[0]);
                        if (k % 5 == 0) begin
                            @(negedge clk);
                            chk("R1 idle hold", e ^ pl[0]);
                        end
                    end
                end
            end
        end

        // R6: master reset clears latch and counter, ignores pulses while high
        set_sel(2); recycle = 1'b0; inv_out = 1'b0;
        do_por(1'b0);
        @(negedge clk);
        for (int k = 1; k <= 5; k++) pulse();
        chk("R4 latched", 1'b1);
        mrst = 1'b1;
        @(negedge clk);
        chk("R6 latch cleared", 1'b0);
        for (int k = 0; k < 3; k++) begin
            pulse();
            chk("R6 pulses during reset", 1'b0);
        end
        mrst = 1'b0;
        @(negedge clk);
        for (int k = 1; k <= 4; k++) begin
            pulse();
            chk("R6 recount after reset", k >= 4);
        end

        // R10: latched, then recycle mode resumes counting from 4
        @(negedge clk);
        @(negedge clk);
        chk("R4 hold after latch", 1'b1);
        recycle = 1'b1;
        @(negedge clk);
        chk("R10 release level", 1'b1);
        for (int k = 5; k <= 8; k++) begin
            pulse();
            chk("R10 resumed count", k < 8);
        end

        // R8: armed wait ignores pulses until a full master-reset pulse
        set_sel(2); recycle = 1'b0; inv_out = 1'b1;
        do_por(1'b1);
        @(negedge clk);
        chk("R8 R5 armed level", 1'b1);
        for (int k = 0; k < 6; k++) begin
            pulse();
            chk("R8 pulses ignored while armed", 1'b1);
        end
        mrst = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            pulse();
            chk("R8 R6 pulses during arming reset", 1'b1);
        end
        mrst = 1'b0;
        @(negedge clk);
        for (int k = 1; k <= 4; k++) begin
            pulse();
            chk("R8 count after arming", (k >= 4) ^ 1'b1);
        end

        // R9: stage code change applies after the next edge; count held at 20
        set_sel(3); recycle = 1'b1; inv_out = 1'b0;
        do_por(1'b0);
        @(negedge clk);
        for (int k = 1; k <= 20; k++) pulse();
        chk("R3 stage 8 at 20", 1'b0);
        set_sel(2);
        #1;
        chk("R9 old tap before edge", 1'b0);
        @(negedge clk);
        chk("R9 new tap bit2 of 20", 1'b1);
        set_sel(1);
        #1;
        chk("R9 old tap before edge", 1'b1);
        @(negedge clk);
        chk("R9 new tap bit3 of 20", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule